// File: doc/BRIEF.md
# Segmented Linear Address Generator

This block turns a segment selector and an offset into a linear address. It has two translation modes, chosen per request. In real-address mode the 16-bit segment value is shifted left by four bits and the low 16 bits of the offset are added to it. The result is a 20-bit address that wraps within a 1 MB space. In descriptor mode the low bits of the selector pick one entry of a small local table of segment descriptors. The entry's 32-bit base is added to the full 32-bit offset. The offset's page number is checked against the entry's limit, which is counted in 4096-byte pages.

Each request yields a registered result one cycle later. The result carries an address-valid flag, a fault flag and the linear address. A separate write port loads descriptor entries. A write is visible to requests issued on any later cycle. A request issued in the same cycle as a write still reads the old entry.

Top module: `lin_addr_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after release, `xl_vld`, `xl_fault` and `xl_addr` are all 0. Every table entry resets to base 0 and limit 0.
- R2: A real-mode request (`rq_mode`=0) gives `xl_addr` = ((`rq_sel` << 4) + `rq_ofs[15:0]`) mod 2^20, zero-extended to 32 bits. `rq_ofs[31:16]` has no effect on the result.
- R3: A real-mode request never faults. Any carry out of bit 19 is dropped, so segment FFFFh with offset FFFFh gives 0FFEFh.
- R4: A descriptor-mode request (`rq_mode`=1) gives `xl_addr` = (base of entry `rq_sel[2:0]` + `rq_ofs`) mod 2^32.
- R5: In descriptor mode, the request faults when `rq_ofs[31:12]` is strictly greater than the entry's limit. On a fault, `xl_fault`=1, `xl_vld`=0 and `xl_addr`=0. An offset whose page number equals the limit does not fault.
- R6: The result of a request issued at a clock edge appears at the outputs right after that edge. A cycle with `rq_vld`=0 gives `xl_vld`=0 and `xl_fault`=0 on the next cycle, and `xl_addr` keeps its last value.
- R7: A write with `wr_en`=1 updates entry `wr_idx` at the clock edge. Requests issued on later cycles see the new base and limit. A request issued in the same cycle as the write sees the previous contents.
- R8: A write changes only the entry it names; all other entries keep their base and limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rq_vld | input | 1 | Translation request strobe |
| rq_mode | input | 1 | 0 = real-address, 1 = descriptor |
| rq_sel | input | 16 | Segment value or selector (bits 2:0 index the table) |
| rq_ofs | input | 32 | Offset |
| wr_en | input | 1 | Descriptor write strobe |
| wr_idx | input | 3 | Entry to write |
| wr_base | input | 32 | New base address |
| wr_limit | input | 20 | New limit in 4096-byte pages |
| xl_vld | output | 1 | Linear address valid |
| xl_fault | output | 1 | Limit violation |
| xl_addr | output | 32 | Linear address |

## Verification
The bench builds the block with its default parameters: a 16-bit segment, a 32-bit offset, a four-bit real-mode shift, 4096-byte pages and an eight-entry table. The 20-bit page number and 20-bit limit can then be driven to exact equality and to one above it. A top segment with a top offset reaches the 1 MB wrap, and a base near the top of 32 bits reaches the 32-bit wrap. A write and a request can be issued together in the same cycle to the same entry, which exercises the read-before-write ordering.

// File: rtl/lag_pkg.sv
package lag_pkg;
  typedef enum logic {
    MODE_REAL = 1'b0,
    MODE_DESC = 1'b1
  } xmode_e;

  localparam int LAG_SEG_W   = 16;
  localparam int LAG_OFS_W   = 32;
  localparam int LAG_IDX_W   = 3;
  localparam int LAG_PAGE_SH = 12;
  localparam int LAG_SEG_SH  = 4;
endpackage

// File: rtl/lag_desc_table.sv
module lag_desc_table #(
  parameter int IDX_W  = lag_pkg::LAG_IDX_W,
  parameter int BASE_W = lag_pkg::LAG_OFS_W,
  parameter int LIM_W  = lag_pkg::LAG_OFS_W - lag_pkg::LAG_PAGE_SH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BASE_W-1:0] wr_base,
  input  logic [LIM_W-1:0]  wr_limit,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BASE_W-1:0] rd_base,
  output logic [LIM_W-1:0]  rd_limit
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [BASE_W-1:0] base_q [ENTRIES];
  logic [LIM_W-1:0]  lim_q  [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic ent_we;
    assign ent_we = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[e] <= '0;
        lim_q[e]  <= '0;
      end else if (ent_we) begin
        base_q[e] <= wr_base;
        lim_q[e]  <= wr_limit;
      end
    end
  end

  // Read sees registered contents only: same-cycle writes land after the edge.
  always_comb begin
    rd_base  = base_q[rd_idx];
    rd_limit = lim_q[rd_idx];
  end
endmodule

// File: rtl/lag_real_path.sv
module lag_real_path #(
  parameter int SEG_W  = lag_pkg::LAG_SEG_W,
  parameter int SEG_SH = lag_pkg::LAG_SEG_SH
) (
  input  logic [SEG_W-1:0]        seg,
  input  logic [SEG_W-1:0]        ofs_lo,
  output logic [SEG_W+SEG_SH-1:0] lin
);
  localparam int REAL_W = SEG_W + SEG_SH;

  logic [REAL_W-1:0] seg_sh;
  logic [REAL_W-1:0] ofs_ext;

  always_comb begin
    seg_sh  = {seg, {SEG_SH{1'b0}}};
    ofs_ext = {{SEG_SH{1'b0}}, ofs_lo};
    lin     = seg_sh + ofs_ext;   // carry past the top bit is dropped
  end
endmodule

// File: rtl/lag_desc_path.sv
module lag_desc_path #(
  parameter int OFS_W   = lag_pkg::LAG_OFS_W,
  parameter int PAGE_SH = lag_pkg::LAG_PAGE_SH
) (
  input  logic [OFS_W-1:0]         base,
  input  logic [OFS_W-PAGE_SH-1:0] limit,
  input  logic [OFS_W-1:0]         ofs,
  output logic [OFS_W-1:0]         lin,
  output logic                     over
);
  localparam int PAGE_W = OFS_W - PAGE_SH;

  logic [PAGE_W-1:0] page;

  always_comb begin
    page = ofs[OFS_W-1:PAGE_SH];
    over = page > limit;
    lin  = base + ofs;
  end
endmodule

// File: rtl/lin_addr_gen.sv
module lin_addr_gen #(
  parameter int SEG_W   = lag_pkg::LAG_SEG_W,
  parameter int OFS_W   = lag_pkg::LAG_OFS_W,
  parameter int IDX_W   = lag_pkg::LAG_IDX_W,
  parameter int PAGE_SH = lag_pkg::LAG_PAGE_SH,
  parameter int SEG_SH  = lag_pkg::LAG_SEG_SH
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rq_vld,
  input  logic                     rq_mode,
  input  logic [SEG_W-1:0]         rq_sel,
  input  logic [OFS_W-1:0]         rq_ofs,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [OFS_W-1:0]         wr_base,
  input  logic [OFS_W-PAGE_SH-1:0] wr_limit,
  output logic                     xl_vld,
  output logic                     xl_fault,
  output logic [OFS_W-1:0]         xl_addr
);
  import lag_pkg::*;

  localparam int REAL_W = SEG_W + SEG_SH;
  localparam int LIM_W  = OFS_W - PAGE_SH;

  logic [OFS_W-1:0]  tb_base;
  logic [LIM_W-1:0]  tb_limit;
  logic [REAL_W-1:0] real_lin;
  logic [OFS_W-1:0]  desc_lin;
  logic              desc_over;
  xmode_e            mode;

  logic              vld_d, fault_d, addr_en;
  logic [OFS_W-1:0]  addr_d;
  logic              vld_q, fault_q;
  logic [OFS_W-1:0]  addr_q;

  assign mode = xmode_e'(rq_mode);

  lag_desc_table #(.IDX_W(IDX_W), .BASE_W(OFS_W), .LIM_W(LIM_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_base  (wr_base),
    .wr_limit (wr_limit),
    .rd_idx   (rq_sel[IDX_W-1:0]),
    .rd_base  (tb_base),
    .rd_limit (tb_limit)
  );

  lag_real_path #(.SEG_W(SEG_W), .SEG_SH(SEG_SH)) u_real (
    .seg    (rq_sel),
    .ofs_lo (rq_ofs[SEG_W-1:0]),
    .lin    (real_lin)
  );

  lag_desc_path #(.OFS_W(OFS_W), .PAGE_SH(PAGE_SH)) u_desc (
    .base  (tb_base),
    .limit (tb_limit),
    .ofs   (rq_ofs),
    .lin   (desc_lin),
    .over  (desc_over)
  );

  // Next-state
  always_comb begin
    addr_en = rq_vld;
    fault_d = rq_vld && (mode == MODE_DESC) && desc_over;
    vld_d   = rq_vld && !fault_d;
    if (fault_d)
      addr_d = '0;
    else if (mode == MODE_DESC)
      addr_d = desc_lin;
    else
      addr_d = {{(OFS_W-REAL_W){1'b0}}, real_lin};
  end

  // State
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      fault_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      vld_q   <= vld_d;
      fault_q <= fault_d;
      if (addr_en) addr_q <= addr_d;
    end
  end

  assign xl_vld   = vld_q;
  assign xl_fault = fault_q;
  assign xl_addr  = addr_q;
endmodule

// File: rtl/lin_addr_gen_chk.sv
module lin_addr_gen_chk #(
  parameter int SEG_W  = lag_pkg::LAG_SEG_W,
  parameter int OFS_W  = lag_pkg::LAG_OFS_W,
  parameter int SEG_SH = lag_pkg::LAG_SEG_SH
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rq_vld,
  input logic             rq_mode,
  input logic [SEG_W-1:0] rq_sel,
  input logic [OFS_W-1:0] rq_ofs,
  input logic             xl_vld,
  input logic             xl_fault,
  input logic [OFS_W-1:0] xl_addr
);
  localparam int REAL_W = SEG_W + SEG_SH;

  AST_VLD_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(xl_vld && xl_fault)); // R5
  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n) xl_fault |-> (xl_addr == '0)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !rq_vld |=> (!xl_vld && !xl_fault)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !rq_vld |=> $stable(xl_addr)); // R6
  AST_REAL_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n) (rq_vld && !rq_mode) |=> (xl_vld && !xl_fault)); // R3
  AST_REAL_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (rq_vld && !rq_mode) |=> (xl_addr[OFS_W-1:REAL_W] == '0)); // R3
  AST_REAL_SUM: assert property (@(posedge clk) disable iff (!rst_n) (rq_vld && !rq_mode) |=> (xl_addr[REAL_W-1:0] == REAL_W'({$past(rq_sel), {SEG_SH{1'b0}}} + {{SEG_SH{1'b0}}, $past(rq_ofs[SEG_W-1:0])}))); // R2
endmodule

bind lin_addr_gen lin_addr_gen_chk #(.SEG_W(SEG_W), .OFS_W(OFS_W), .SEG_SH(SEG_SH)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .rq_vld   (rq_vld),
  .rq_mode  (rq_mode),
  .rq_sel   (rq_sel),
  .rq_ofs   (rq_ofs),
  .xl_vld   (xl_vld),
  .xl_fault (xl_fault),
  .xl_addr  (xl_addr)
);

// File: tb/lin_addr_gen_tb_top.sv
module lin_addr_gen_tb_top;
  logic        clk;
  logic        rst_n;
  logic        rq_vld, rq_mode;
  logic [15:0] rq_sel;
  logic [31:0] rq_ofs;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic [31:0] wr_base;
  logic [19:0] wr_limit;
  logic        xl_vld, xl_fault;
  logic [31:0] xl_addr;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] m_base [8];
  logic [19:0] m_lim  [8];
  logic [31:0] e_addr;

  lin_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .rq_vld(rq_vld), .rq_mode(rq_mode),
    .rq_sel(rq_sel), .rq_ofs(rq_ofs), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_base(wr_base), .wr_limit(wr_limit), .xl_vld(xl_vld),
    .xl_fault(xl_fault), .xl_addr(xl_addr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] f_real(input logic [15:0] s, input logic [31:0] o);
    logic [19:0] r;
    r = {s, 4'h0} + {4'h0, o[15:0]};
    return {12'h0, r};
  endfunction

  task automatic chk(input string req, input logic [33:0] act, input logic [33:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual vld/fault/addr=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, model, then check at the next falling edge.
  task automatic step(input logic v, input logic m, input logic [15:0] s,
                      input logic [31:0] o, input logic we, input logic [2:0] wi,
                      input logic [31:0] wb, input logic [19:0] wl, input string req);
    logic ev, ef;
    logic [2:0] ix;
    rq_vld = v; rq_mode = m; rq_sel = s; rq_ofs = o;
    wr_en = we; wr_idx = wi; wr_base = wb; wr_limit = wl;
    ix = s[2:0];
    ev = 1'b0; ef = 1'b0;
    if (v) begin
      if (m) begin
        ef = o[31:12] > m_lim[ix];
        e_addr = ef ? 32'h0 : m_base[ix] + o;
      end else
        e_addr = f_real(s, o);
      ev = !ef;
    end
    if (we) begin m_base[wi] = wb; m_lim[wi] = wl; end
    @(negedge clk);
    chk(req, {xl_vld, xl_fault, xl_addr}, {ev, ef, e_addr});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_base[i] = '0; m_lim[i] = '0; end
    e_addr = '0;
    rst_n = 1'b0;
    rq_vld = 0; rq_mode = 0; rq_sel = 0; rq_ofs = 0;
    wr_en = 0; wr_idx = 0; wr_base = 0; wr_limit = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 in reset", {xl_vld, xl_fault, xl_addr}, 34'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {xl_vld, xl_fault, xl_addr}, 34'h0);
    // R1: reset table gives base 0 limit 0
    step(1, 1, 16'h0003, 32'h0000_0FFF, 0, 0, 0, 0, "R1 reset entry in range");
    step(1, 1, 16'h0003, 32'h0000_1000, 0, 0, 0, 0, "R1 reset entry limit");
    // R2 worked values
    step(1, 0, 16'h08F1, 32'h0000_0100, 0, 0, 0, 0, "R2 08F1:0100");
    step(1, 0, 16'h028F, 32'h0000_0030, 0, 0, 0, 0, "R2 028F:0030");
    step(1, 0, 16'h028F, 32'hABCD_0030, 0, 0, 0, 0, "R2 upper offset ignored");
    // R3 wrap
    step(1, 0, 16'hFFFF, 32'h0000_FFFF, 0, 0, 0, 0, "R3 wrap 1MB");
    // R6 idle holds address
    step(0, 1, 16'h0000, 32'hFFFF_FFFF, 0, 0, 0, 0, "R6 idle");
    step(0, 0, 16'h1234, 32'h0, 0, 0, 0, 0, "R6 idle hold");
    // R7 write, then use
    step(0, 0, 0, 0, 1, 3'd2, 32'h0002_6000, 20'h00010, "R7 write entry 2");
    step(1, 1, 16'h0002, 32'h0001_0FFF, 0, 0, 0, 0, "R5 page equals limit");
    step(1, 1, 16'h0002, 32'h0001_1000, 0, 0, 0, 0, "R5 page above limit");
    step(1, 1, 16'h0002, 32'h0000_0250, 0, 0, 0, 0, "R4 base plus offset");
    // R7 same cycle: old contents seen, new on next cycle
    step(1, 1, 16'h0005, 32'h0000_0010, 1, 3'd5, 32'h1000_0000, 20'hFFFFF, "R7 same-cycle old");
    step(1, 1, 16'h0005, 32'h0000_0010, 0, 0, 0, 0, "R7 next-cycle new");
    // R4 32-bit wrap
    step(1, 1, 16'h0005, 32'hF000_2000, 0, 0, 0, 0, "R4 wrap 32-bit");
    // R8 entry 2 untouched by write to 5
    step(1, 1, 16'h000A, 32'h0001_0000, 0, 0, 0, 0, "R8 other entry kept");
    step(1, 1, 16'h0004, 32'h0000_0000, 0, 0, 0, 0, "R8 unwritten entry");
    // Random mix
    for (int k = 0; k < 400; k++) begin
      logic [31:0] o;
      o = $urandom;
      if ($urandom_range(0, 1) == 0) o = o & 32'h000F_FFFF;
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, 16'($urandom), o,
           $urandom_range(0, 3) == 0, 3'($urandom), $urandom, 20'($urandom_range(0, 512)),
           "R4/R5/R2/R7 random");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule